// File: doc/BRIEF.md
# Sparsifying Hit Data Combiner

The block gathers over-threshold hit data from thirteen front-end inputs once per beam crossing. Each input carries 32 channels, and each channel is a single hit bit with no amplitude. When the crossing strobe is high, the block captures all 416 bits. It then turns them into one framed block for a downstream serializer.

A block starts with a header word. The header holds an 8-bit crossing number and a mask of the inputs that saw at least one hit. One 32-bit word follows for each flagged input, so inputs with no hits take no space. The output is a word stream with a valid/ready handshake and start and end markers.

There are two capture slots. While one block is being sent, the next crossing can be stored. A crossing that arrives while both slots still hold unfinished blocks is discarded and a sticky overflow flag is set. The crossing number keeps counting, so the lost crossing shows up as a gap in the sequence. The system clock gives seven cycles per crossing, which is enough for a block of up to six words.

Top module: `hit_combiner`

## Requirements
- R1: After a synchronous active-low reset, out_valid and overflow are 0.
- R2: The first word of a block is the header. Bits 31:24 hold the crossing number, bits 23:13 are zero, and bit i of bits 12:0 is 1 exactly when input i (hit_in bits 32*i+31 to 32*i) is non-zero. out_sob is high on the header only.
- R3: After the header come the raw 32-bit words of the flagged inputs only, in ascending input index.
- R4: A crossing with no hits gives a header-only block with mask 0. out_sob and out_eob are both high on that word.
- R5: out_eob is high on the last word of each block and on no other word. out_sob and out_eob are never high while out_valid is low.
- R6: The crossing number is 0 for the first strobe after reset. It increases by one on every strobe, including dropped ones, and wraps from 255 to 0.
- R7: The header of a captured crossing is presented in the cycle after the strobe if no other block is pending. While out_valid is high and out_ready is low, out_data, out_sob and out_eob hold.
- R8: Up to two unfinished blocks are held. A strobe that arrives while two unfinished blocks are held is dropped, judged before any completion in that same cycle. overflow then goes high and stays high until reset.
- R9: Blocks leave in crossing order. The next header is presented in the cycle after the last word of the previous block is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xing_stb | input | 1 | One-cycle strobe: capture hit_in for a new crossing |
| hit_in | input | 416 | Hit bits, input i in bits 32*i+31 to 32*i |
| out_data | output | 32 | Header or data word |
| out_valid | output | 1 | out_data holds a word |
| out_sob | output | 1 | Word is a block header |
| out_eob | output | 1 | Word is the last of its block |
| out_ready | input | 1 | Downstream accepts the word this cycle |
| overflow | output | 1 | Sticky: a crossing was dropped |

## Verification
A wrong slot pointer or occupancy count shows up as a header with the wrong crossing number, or as a repeated or missing block. This is visible at the first word after the error. A wrong pending mask gives wrong data words, or an out_eob that comes too early or too late, within the same block. A full-slot test uses held-off ready. A 270-crossing run checks the counter wrap. A per-cycle reference comparison finds any such divergence in the cycle it happens.

// File: rtl/hit_combiner.sv
module hit_combiner #(
  parameter int NUM_IN = 13,
  parameter int CH     = 32,
  parameter int CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xing_stb,
  input  logic [NUM_IN*CH-1:0] hit_in,
  output logic [CH-1:0]        out_data,
  output logic                 out_valid,
  output logic                 out_sob,
  output logic                 out_eob,
  input  logic                 out_ready,
  output logic                 overflow
);
  localparam int PAD   = CH - CNT_W - NUM_IN;
  localparam int IDX_W = $clog2(NUM_IN);

  logic [NUM_IN*CH-1:0] bd [2];
  logic [NUM_IN-1:0]    bm [2];
  logic [CNT_W-1:0]     bc [2];
  logic                 wr, rd, hdr;
  logic [1:0]           cnt;
  logic [NUM_IN-1:0]    pend, in_mask;
  logic [CNT_W-1:0]     xing;
  logic [IDX_W-1:0]     sel;

  always_comb
    for (int i = 0; i < NUM_IN; i++) in_mask[i] = |hit_in[i*CH +: CH];

  always_comb begin
    sel = '0;
    for (int i = NUM_IN - 1; i >= 0; i--)
      if (pend[i]) sel = IDX_W'(i);
  end

  wire last = hdr ? (bm[rd] == '0) : ((pend & (pend - 1'b1)) == '0);
  wire fire = out_valid && out_ready;
  wire pop  = fire && last;
  wire push = xing_stb && (cnt != 2'd2);

  assign out_valid = (cnt != 2'd0);
  assign out_sob   = out_valid && hdr;
  assign out_eob   = out_valid && last;
  assign out_data  = hdr ? {bc[rd], {PAD{1'b0}}, bm[rd]} : bd[rd][sel*CH +: CH];

  always_ff @(posedge clk)
    if (push) begin
      bd[wr] <= hit_in;
      bm[wr] <= in_mask;
      bc[wr] <= xing;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr <= 1'b0; rd <= 1'b0; cnt <= 2'd0; hdr <= 1'b1;
      pend <= '0; xing <= '0; overflow <= 1'b0;
    end else begin
      if (xing_stb) begin
        xing <= xing + 1'b1;
        if (cnt == 2'd2) overflow <= 1'b1;
      end
      if (push) wr <= ~wr;
      if (fire) begin
        if (hdr) begin
          hdr  <= last;
          pend <= bm[rd];
        end else begin
          pend <= pend & (pend - 1'b1);
          if (last) hdr <= 1'b1;
        end
      end
      if (pop) rd <= ~rd;
      cnt <= cnt + {1'b0, push} - {1'b0, pop};
    end
  end
endmodule

// File: rtl/hit_combiner_chk.sv
module hit_combiner_chk #(
  parameter int NUM_IN = 13,
  parameter int CH     = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CH-1:0] out_data,
  input logic          out_valid,
  input logic          out_sob,
  input logic          out_eob,
  input logic          out_ready,
  input logic          overflow
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !overflow);

  a_r5_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_sob && !out_eob);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sob) && $stable(out_eob));

  a_r8_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r2_header_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sob |-> out_data[23:13] == '0);

  a_r4_empty_is_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sob && out_data[NUM_IN-1:0] == '0 |-> out_eob);
endmodule

bind hit_combiner hit_combiner_chk #(.NUM_IN(NUM_IN), .CH(CH)) u_chk (.*);

// File: tb/tb_hit_combiner.sv
module tb_hit_combiner;
  localparam int NI = 13;
  localparam int CW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            xing_stb = 1'b0;
  logic [NI*CW-1:0] hit_in = '0;
  logic [CW-1:0]   out_data;
  logic            out_valid, out_sob, out_eob, overflow;
  logic            out_ready;
  logic            ready_force = 1'b1;
  bit              rand_ready = 1'b0;

  hit_combiner dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: queue of {sob, eob, word}
  logic [CW+1:0] q[$];
  bit   m_ovf = 0;
  int   m_x = 0;
  int   occ;
  bit   m_fire;
  logic [NI-1:0] mk;
  int   lastidx;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ovf = 0; m_x = 0;
    end else begin
      occ = 0;
      foreach (q[k]) if (q[k][CW]) occ++;
      m_fire = (q.size() > 0) && out_ready;
      if (m_fire) void'(q.pop_front());
      if (xing_stb) begin
        if (occ == 2) m_ovf = 1;
        else begin
          for (int i = 0; i < NI; i++) mk[i] = |hit_in[i*CW +: CW];
          lastidx = -1;
          for (int i = 0; i < NI; i++) if (mk[i]) lastidx = i;
          q.push_back({1'b1, mk == '0, 8'(m_x), 11'b0, mk});
          for (int i = 0; i < NI; i++)
            if (mk[i]) q.push_back({1'b0, i == lastidx, hit_in[i*CW +: CW]});
        end
        m_x = (m_x + 1) % 256;
      end
    end
  end

  bit            prev_stall = 0;
  logic [CW-1:0] prev_data;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == (q.size() > 0), "R7 R9 valid", out_valid, q.size() > 0);
      if (out_valid && q.size() > 0) begin
        check(out_data == q[0][CW-1:0], q[0][CW+1] ? "R2 R6 header" : "R3 data",
              out_data, q[0][CW-1:0]);
        check(out_sob == q[0][CW+1], "R2 sob", out_sob, q[0][CW+1]);
        check(out_eob == q[0][CW], "R5 R4 eob", out_eob, q[0][CW]);
      end
      if (!out_valid) check(!out_sob && !out_eob, "R5 flags idle", {out_sob, out_eob}, 0);
      if (prev_stall) check(out_data == prev_data, "R7 hold", out_data, prev_data);
      check(overflow == m_ovf, "R8 overflow", overflow, m_ovf);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end else prev_stall = 0;
  end

  always @(posedge clk) begin
    #1;
    out_ready = rand_ready ? ($urandom % 3 != 0) : ready_force;
  end
  initial out_ready = 1'b1;

  function automatic logic [NI*CW-1:0] make_hits(input logic [NI-1:0] m);
    logic [NI*CW-1:0] h = '0;
    for (int i = 0; i < NI; i++) if (m[i]) h[i*CW +: CW] = $urandom | 32'h1;
    return h;
  endfunction

  task automatic strobe(input logic [NI-1:0] m, input int gap);
    @(posedge clk); #1;
    hit_in = make_hits(m); xing_stb = 1'b1;
    @(posedge clk); #1;
    xing_stb = 1'b0; hit_in = '0;
    repeat (gap) @(posedge clk);
  endtask

  function automatic logic [NI-1:0] sparse();
    logic [NI-1:0] m = '0;
    for (int k = 0; k < 3; k++) if ($urandom % 2) m[$urandom % NI] = 1'b1;
    return m;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!out_valid && !overflow, "R1 reset", {out_valid, overflow}, 0);

    // R4 empty crossing: header appears next cycle (R7)
    strobe('0, 0);
    @(negedge clk);
    check(out_valid && out_sob && out_eob && out_data == 32'h0, "R4 empty block",
          out_data, 0);
    repeat (6) @(posedge clk);

    // R2 R3 sparse crossings at crossing rate
    for (int n = 0; n < 20; n++) strobe(sparse(), 5);

    // R3 single highest input and single lowest input
    strobe(13'h1000, 5);
    strobe(13'h0001, 5);

    // R7 R9 random backpressure, wider spacing
    rand_ready = 1;
    for (int n = 0; n < 30; n++) strobe(sparse() | 13'h0010, 14);
    rand_ready = 0;
    repeat (40) @(posedge clk);

    // R6 counter wrap past 255
    for (int n = 0; n < 270; n++) strobe(n % 5 == 0 ? 13'h0105 : 13'h0, 5);
    repeat (20) @(posedge clk);

    // R8 overflow: stall with two pending blocks, third strobe dropped
    ready_force = 1'b0;
    strobe(13'h1FFF, 1);
    strobe(13'h0003, 1);
    strobe(13'h0002, 1);
    @(negedge clk);
    check(overflow === 1'b1, "R8 drop sets overflow", overflow, 1);
    ready_force = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(!out_valid && overflow, "R8 sticky after drain", {out_valid, overflow}, 1);

    // R9 back-to-back full blocks
    strobe(13'h1FFF, 0);
    strobe(13'h0800, 30);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule